// File: doc/BRIEF.md
# Saturating Cache Hit/Miss Monitors

This block keeps two performance counters for an instruction cache. One counts lookup hits and the other counts lookup misses. The cache lookup logic signals each event with a single-cycle strobe, and the block only counts those strobes. Each counter has its own enable bit and its own synchronous clear bit in one control register. Software reads the control register and both counts through a small register interface. The counts are also available directly as output ports.

The counters stop at their all-ones value and never wrap, so a long measurement can never report a small, wrong number. A clear is done by writing a clear bit to one and later writing it back to zero. The counter reads zero for the whole time the clear bit stays set. The counter widths are parameters. By default the hit counter is 32 bits wide and the miss counter is 16 bits wide.

Top module: `perfmon_top`

## Requirements
- R1: After the block reset, the control register reads 0 and both counters read 0.
- R2: While control bit 0 (hit enable) is set and hit clear is not set, each clock with `hit_evt` high raises the hit count by exactly one.
- R3: While control bit 1 (miss enable) is set and miss clear is not set, each clock with `miss_evt` high raises the miss count by exactly one.
- R4: A counter whose enable bit is clear keeps its value, whatever its strobe does. Strobes of one counter never change the other counter.
- R5: The hit count (default width 32, all-ones 0xFFFFFFFF) stops at all ones. Further enabled hits leave it unchanged.
- R6: The miss count (default width 16, all-ones 0xFFFF) stops at all ones. Further enabled misses leave it unchanged.
- R7: Control bit 2 (hit clear) and bit 3 (miss clear) sit two positions above their enable bits. On every clock where a clear bit is set, its counter is loaded with 0. The counter counts again once the bit is written back to 0.
- R8: If a clear bit is set, it wins over an enabled strobe in the same cycle, and the counter goes to 0.
- R9: Reads are combinational on `rd_addr`. Address 0 returns the control register, 1 the hit count, 2 the miss count and 3 returns zero. Counts are zero-extended to the data width.
- R10: A write to address 0 takes effect at the next clock. It stores only bits 3:0. Higher data bits are ignored and read back as 0. Writes to other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| hit_evt | input | 1 | Single-cycle hit strobe from the cache lookup |
| miss_evt | input | 1 | Single-cycle miss strobe from the cache lookup |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DATA_W (32) | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DATA_W (32) | Combinational read data |
| hit_count | output | HIT_W (32) | Current hit count |
| miss_count | output | MISS_W (16) | Current miss count |

## Verification
A control write at one clock edge changes the read-back value right after that edge. The new enable or clear then acts on the counters at the following edge. A strobe shows in its count one edge after it is sampled, and a held clear reads zero one edge after the clear bit is stored. The bench drives inputs just after each rising edge. It advances its reference model on the same rising edges as the design and compares every output at the falling edge, so every result is sampled in the cycle it is due. The test bench uses narrow counters so that both saturation points can be reached.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

    localparam int ADDR_W = 2;
    localparam int CTRL_W = 4;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_HIT  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_MISS = 2'd2;

    // bit order matters: each clear sits two above its enable
    typedef struct packed {
        logic miss_clr;   // bit 3
        logic hit_clr;    // bit 2
        logic miss_en;    // bit 1
        logic hit_en;     // bit 0
    } ctrl_t;

endpackage

// File: rtl/perfmon_ctrl.sv
module perfmon_ctrl
    import perfmon_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl
);

    typedef struct packed {
        ctrl_t ctrl;
    } state_t;

    state_t s_d, s_q;

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data[DATA_W-1:CTRL_W];

    always_comb begin
        s_d = s_q;
        if (wr_en && (wr_addr == ADDR_CTRL)) begin
            s_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl = s_q.ctrl;

endmodule

// File: rtl/perfmon_satcnt.sv
module perfmon_satcnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         clr,
    input  logic         evt,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.cnt = '0;
        end else if (en && evt && (s_q.cnt != TOP)) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count = s_q.cnt;

endmodule

// File: rtl/perfmon_top.sv
module perfmon_top
    import perfmon_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HIT_W  = 32,
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_evt,
    input  logic              miss_evt,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [HIT_W-1:0]  hit_count,
    output logic [MISS_W-1:0] miss_count
);

    ctrl_t ctrl;
    logic  hit_en, miss_en, hit_clr, miss_clr;

    perfmon_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl    (ctrl)
    );

    assign hit_en   = ctrl.hit_en;
    assign miss_en  = ctrl.miss_en;
    assign hit_clr  = ctrl.hit_clr;
    assign miss_clr = ctrl.miss_clr;

    perfmon_satcnt #(.W(HIT_W)) u_hit (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (hit_en),
        .clr   (hit_clr),
        .evt   (hit_evt),
        .count (hit_count)
    );

    perfmon_satcnt #(.W(MISS_W)) u_miss (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (miss_en),
        .clr   (miss_clr),
        .evt   (miss_evt),
        .count (miss_count)
    );

    always_comb begin
        unique case (rd_addr)
            ADDR_CTRL: rd_data = DATA_W'(ctrl);
            ADDR_HIT:  rd_data = DATA_W'(hit_count);
            ADDR_MISS: rd_data = DATA_W'(miss_count);
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/perfmon_checker.sv
module perfmon_checker #(
    parameter int HIT_W  = 32,
    parameter int MISS_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hit_evt,
    input logic              miss_evt,
    input logic              hit_en,
    input logic              miss_en,
    input logic              hit_clr,
    input logic              miss_clr,
    input logic [HIT_W-1:0]  hit_count,
    input logic [MISS_W-1:0] miss_count
);

    localparam logic [HIT_W-1:0]  HTOP = {HIT_W{1'b1}};
    localparam logic [MISS_W-1:0] MTOP = {MISS_W{1'b1}};

    assert_hit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_en && hit_evt && !hit_clr && hit_count != HTOP)
        |=> hit_count == $past(hit_count) + 1'b1);

    assert_miss_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_en && miss_evt && !miss_clr && miss_count != MTOP)
        |=> miss_count == $past(miss_count) + 1'b1);

    assert_hit_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_en && !hit_clr) |=> $stable(hit_count));

    assert_miss_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!miss_en && !miss_clr) |=> $stable(miss_count));

    assert_hit_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_count == HTOP && !hit_clr) |=> hit_count == HTOP);

    assert_miss_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_count == MTOP && !miss_clr) |=> miss_count == MTOP);

    assert_hit_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_clr |=> hit_count == '0);

    assert_miss_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        miss_clr |=> miss_count == '0);

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_clr && hit_en && hit_evt) |=> hit_count == '0);

endmodule

bind perfmon_top perfmon_checker #(.HIT_W(HIT_W), .MISS_W(MISS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_evt    (hit_evt),
    .miss_evt   (miss_evt),
    .hit_en     (hit_en),
    .miss_en    (miss_en),
    .hit_clr    (hit_clr),
    .miss_clr   (miss_clr),
    .hit_count  (hit_count),
    .miss_count (miss_count)
);

// File: tb/perfmon_top_test.sv
module perfmon_top_test;

    localparam int PERIOD = 10;
    localparam int DATA_W = 32;
    localparam int HIT_W  = 10;
    localparam int MISS_W = 6;
    localparam longint HMAX = (64'd1 << HIT_W) - 1;
    localparam longint MMAX = (64'd1 << MISS_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hit_evt = 1'b0, miss_evt = 1'b0, wr_en = 1'b0;
    logic [1:0]        wr_addr = '0, rd_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic [HIT_W-1:0]  hit_count;
    logic [MISS_W-1:0] miss_count;

    int checks = 0, errors = 0;
    bit done = 0, live = 0;
    string tag = "R1";

    // behavioural reference state
    longint m_hit = 0, m_miss = 0;
    int     m_ctrl = 0;

    always #(PERIOD/2) clk = ~clk;

    perfmon_top #(.DATA_W(DATA_W), .HIT_W(HIT_W), .MISS_W(MISS_W)) uut (
        .clk(clk), .rst_n(rst_n), .hit_evt(hit_evt), .miss_evt(miss_evt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hit <= 0; m_miss <= 0; m_ctrl <= 0;
        end else begin
            if (m_ctrl[2]) m_hit <= 0;
            else if (m_ctrl[0] && hit_evt && m_hit < HMAX) m_hit <= m_hit + 1;
            if (m_ctrl[3]) m_miss <= 0;
            else if (m_ctrl[1] && miss_evt && m_miss < MMAX) m_miss <= m_miss + 1;
            if (wr_en && wr_addr == 2'd0) m_ctrl <= int'(wr_data[3:0]);
        end
    end

    function automatic longint exp_rd(logic [1:0] a);
        case (a)
            2'd0: return longint'(m_ctrl);
            2'd1: return m_hit;
            2'd2: return m_miss;
            default: return 0;
        endcase
    endfunction

    always @(negedge clk) begin
        if (live) begin
            check({tag, " hit_count"}, longint'(hit_count), m_hit);
            check({tag, " miss_count"}, longint'(miss_count), m_miss);
            check({tag, " R9 rd_data"}, longint'(rd_data), exp_rd(rd_addr));
        end
    end

    task automatic drive(bit h, bit m, bit we, logic [1:0] wa, logic [DATA_W-1:0] wd);
        @(posedge clk); #1;
        hit_evt = h; miss_evt = m; wr_en = we; wr_addr = wa; wr_data = wd;
        rd_addr = rd_addr + 2'd1;
    endtask

    task automatic wr_ctrl(logic [DATA_W-1:0] v);
        drive(0, 0, 1, 2'd0, v);
        drive(0, 0, 0, 2'd0, '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd_addr = 2'd0; #1;
        check("R1 ctrl", longint'(rd_data), 0);
        check("R1 hit", longint'(hit_count), 0);
        check("R1 miss", longint'(miss_count), 0);
        live = 1;

        tag = "R2";
        wr_ctrl(32'h1);
        for (int i = 0; i < 20; i++) drive(i % 3 != 0, i % 2 == 0, 0, 2'd0, '0);
        @(negedge clk);
        check("R4 miss untouched", longint'(miss_count), 0);

        tag = "R3";
        wr_ctrl(32'h3);
        for (int i = 0; i < 30; i++) drive($urandom_range(1), $urandom_range(1), 0, 2'd0, '0);

        tag = "R4";
        wr_ctrl(32'h2);
        for (int i = 0; i < 10; i++) drive(1, 0, 0, 2'd0, '0);
        wr_ctrl(32'h0);
        for (int i = 0; i < 10; i++) drive(1, 1, 0, 2'd0, '0);

        tag = "R7";
        wr_ctrl(32'h3);
        for (int i = 0; i < 5; i++) drive(1, 1, 0, 2'd0, '0);
        // R8: clear held while strobes keep arriving
        drive(1, 1, 1, 2'd0, 32'h7);
        for (int i = 0; i < 6; i++) drive(1, 1, 0, 2'd0, '0);
        @(negedge clk);
        check("R8 hit cleared despite strobe", longint'(hit_count), 0);
        drive(1, 1, 1, 2'd0, 32'h3);
        for (int i = 0; i < 4; i++) drive(1, 0, 0, 2'd0, '0);
        drive(0, 1, 1, 2'd0, 32'hB);
        for (int i = 0; i < 4; i++) drive(1, 1, 0, 2'd0, '0);
        @(negedge clk);
        check("R7 miss cleared", longint'(miss_count), 0);
        wr_ctrl(32'h3);

        tag = "R6";
        for (int i = 0; i < int'(MMAX) + 8; i++) drive(0, 1, 0, 2'd0, '0);
        @(negedge clk);
        check("R6 miss saturated", longint'(miss_count), MMAX);

        tag = "R5";
        for (int i = 0; i < int'(HMAX) + 8; i++) drive(1, 1, 0, 2'd0, '0);
        @(negedge clk);
        check("R5 hit saturated", longint'(hit_count), HMAX);

        tag = "R10";
        drive(0, 0, 1, 2'd0, 32'hFFFF_FFF1);
        drive(0, 0, 1, 2'd1, 32'h0000_000C);
        drive(0, 0, 0, 2'd0, '0);
        @(negedge clk);
        rd_addr = 2'd0; #1;
        check("R10 ctrl upper bits dropped", longint'(rd_data), 1);
        rd_addr = 2'd3; #1;
        check("R9 unused address", longint'(rd_data), 0);
        for (int i = 0; i < 8; i++) drive(1, 1, 0, 2'd0, '0);

        live = 0;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all) actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule